// File: doc/BRIEF.md
# Memory Type Range Resolver

This block answers one question for a memory subsystem: which cacheability type applies to a physical address range given as a start address and an exclusive end address. It draws on three sources of configuration. The first is a table of 88 type bytes that covers the lowest megabyte at three granularities. The second is a set of `NUM_VAR` variable regions, each defined by a base word and a mask word. The third is an optional upper boundary for a write-back window located above 4 GiB.

Configuration is written through a single-cycle write port. Each write selects a register kind and an index. A lookup starts with a one-cycle `req_start` pulse while the block is idle. The block then steps through the variable regions at one region per clock. It raises `done` for exactly one cycle, and `result` holds the resolved type during that cycle.

Type codes: uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06. The code 0xFE means the range is only partly covered by a variable region. The code 0xFF means resolution is switched off.

Top module: `memtype_resolver`

## Requirements
- R1: Before any control word has been written, or when both enable bits of the control word are clear, the result is 0xFF. The control word is kind 0, and its fields are: bits 7:0 default type, bit 8 fixed-table enable, bit 9 variable-region enable, bit 10 fixed table present.
- R2: The exclusive end address is reduced by one before any comparison. A range that ends exactly at a region's upper limit therefore counts as inside that region.
- R3: The fixed table is consulted only when it is present and enabled and the start address is below 0x100000. In that case the type comes from the start address alone. The index is start>>16 below 0x80000, 8+((start-0x80000)>>14) below 0xC0000, and 24+((start-0xC0000)>>12) otherwise. Bytes are written as kind 1, with the index selecting the entry and data bits 7:0 giving the type.
- R4: When the variable-region enable is clear and the fixed table does not apply, the result is the default type.
- R5: A variable region takes part only when bit 11 of its mask word is set. The base word is kind 2 and the mask word is kind 3. The region's type is bits 7:0 of its base word. Address bits 11:0 of both words play no part in matching.
- R6: A region matches an address when (addr & mask) equals (base & mask). If an active region matches exactly one of start and the inclusive end, the result is 0xFE and the remaining regions are skipped.
- R7: When several regions match, any uncacheable type makes the result uncacheable. Write-back combined with write-through gives write-through. Any other disagreement gives uncacheable, and a conflict ends the scan immediately.
- R8: When the top-of-memory-2 value (kind 4) is nonzero, the start is at or above 4 GiB, and the inclusive end is below that value, a completed scan yields write-back regardless of the matches.
- R9: When no active region matches, the result is the default type.
- R10: A request is accepted only while idle. `req_start` has no effect while busy. `done` is a one-cycle pulse. A scan that runs to completion raises `done` `NUM_VAR`+2 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register kind: 0 control, 1 fixed byte, 2 region base, 3 region mask, 4 top-of-memory-2 |
| cfg_idx | input | CFG_IDX_W (7) | Entry index for fixed bytes and regions |
| cfg_data | input | ADDR_W (40) | Write data |
| req_start | input | 1 | Lookup request pulse |
| req_base | input | ADDR_W (40) | Range start address |
| req_end | input | ADDR_W (40) | Range end address, exclusive |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle result strobe |
| result | output | 8 | Resolved type, valid while done is high |

## Verification
The assertions assume that configuration is not rewritten while a lookup is in flight. For example, the check that a mixed-coverage result implies the variable enable was set compares `done` against the enable bit as it stands at that moment. The bench writes all configuration between lookups and waits for `done` before it changes anything. The assertions also take `req_start` to be meaningful only while idle. The bench deliberately pulses it during a scan only to confirm that such pulses are dropped. Region layouts in the bench are chosen so that each lookup reaches a single, predictable outcome: one match, a pair, a straddle, or no match.

// File: rtl/mtr_pkg.sv
// Shared constants, types and the overlap-precedence function for the
// memory type range resolver. Assumes type codes are 8 bits wide.
package mtr_pkg;

    localparam logic [7:0] MT_UC    = 8'h00;
    localparam logic [7:0] MT_WC    = 8'h01;
    localparam logic [7:0] MT_WT    = 8'h04;
    localparam logic [7:0] MT_WP    = 8'h05;
    localparam logic [7:0] MT_WB    = 8'h06;
    localparam logic [7:0] MT_MIXED = 8'hFE;
    localparam logic [7:0] MT_OFF   = 8'hFF;

    // Fixed table layout: 8 x 64K, 16 x 16K, 64 x 4K entries.
    localparam int FIX_SLOTS = 88;
    localparam int FIX_IDX_W = 7;

    typedef enum logic [2:0] {
        CFG_CTRL = 3'd0,
        CFG_FIX  = 3'd1,
        CFG_BASE = 3'd2,
        CFG_MASK = 3'd3,
        CFG_TOM2 = 3'd4
    } cfg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SCAN,
        ST_POST,
        ST_FIN
    } scan_state_e;

    typedef struct packed {
        logic [7:0] ty;
        logic       conflict;
    } merge_t;

    // Fold a newly matching type into the accumulated one.
    function automatic merge_t merge_types(input logic have,
                                           input logic [7:0] acc,
                                           input logic [7:0] cur);
        merge_t r;
        r.ty       = acc;
        r.conflict = 1'b0;
        if (!have) begin
            r.ty = cur;
        end else if (acc == MT_UC || cur == MT_UC) begin
            r.ty       = MT_UC;
            r.conflict = 1'b1;
        end else if ((acc == MT_WB && cur == MT_WT) ||
                     (acc == MT_WT && cur == MT_WB)) begin
            r.ty = MT_WT;
        end else if (acc != cur) begin
            r.ty       = MT_UC;
            r.conflict = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mtr_cfg_store.sv
// Configuration storage: control word, fixed type table, variable region
// base/mask words and the top-of-memory-2 boundary. Writes outside the
// populated index range are dropped. Assumes one write per cycle.
module mtr_cfg_store
    import mtr_pkg::*;
#(
    parameter int ADDR_W    = 40,
    parameter int NUM_VAR   = 8,
    parameter int CFG_IDX_W = 7
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [2:0]                          kind,
    input  logic [CFG_IDX_W-1:0]                idx,
    input  logic [ADDR_W-1:0]                   data,
    output logic                                loaded,
    output logic [7:0]                          def_type,
    output logic                                fix_en,
    output logic                                var_en,
    output logic                                fix_present,
    output logic [ADDR_W-1:0]                   tom2,
    output logic [FIX_SLOTS-1:0][7:0]           fix_tab,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]      base_w,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]      mask_w
);

    logic wr_ctrl, wr_fix, wr_base, wr_mask, wr_tom2;

    // Decode the write kind once for all storage below.
    always_comb begin
        wr_ctrl = we && (cfg_kind_e'(kind) == CFG_CTRL);
        wr_fix  = we && (cfg_kind_e'(kind) == CFG_FIX);
        wr_base = we && (cfg_kind_e'(kind) == CFG_BASE);
        wr_mask = we && (cfg_kind_e'(kind) == CFG_MASK);
        wr_tom2 = we && (cfg_kind_e'(kind) == CFG_TOM2);
    end

    // Control word and the loaded flag it sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loaded      <= 1'b0;
            def_type    <= 8'h00;
            fix_en      <= 1'b0;
            var_en      <= 1'b0;
            fix_present <= 1'b0;
        end else if (wr_ctrl) begin
            loaded      <= 1'b1;
            def_type    <= data[7:0];
            fix_en      <= data[8];
            var_en      <= data[9];
            fix_present <= data[10];
        end
    end

    // Top-of-memory-2 boundary register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tom2 <= '0;
        end else if (wr_tom2) begin
            tom2 <= data;
        end
    end

    // One byte register per fixed table slot.
    for (genvar g = 0; g < FIX_SLOTS; g++) begin : g_fix
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fix_tab[g] <= 8'h00;
            end else if (wr_fix && idx == CFG_IDX_W'(g)) begin
                fix_tab[g] <= data[7:0];
            end
        end
    end

    // Base and mask word pair per variable region.
    for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_w[v] <= '0;
                mask_w[v] <= '0;
            end else begin
                if (wr_base && idx == CFG_IDX_W'(v)) base_w[v] <= data;
                if (wr_mask && idx == CFG_IDX_W'(v)) mask_w[v] <= data;
            end
        end
    end

endmodule

// File: rtl/mtr_fixed_index.sv
// Maps a start address to a fixed table slot across the three
// granularities (64K, 16K, 4K). Assumes ADDR_W of at least 21.
module mtr_fixed_index
    import mtr_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 in_fixed,
    output logic [FIX_IDX_W-1:0] slot
);

    localparam logic [ADDR_W-1:0] LIM_64K = ADDR_W'(32'h0008_0000);
    localparam logic [ADDR_W-1:0] LIM_16K = ADDR_W'(32'h000C_0000);
    localparam logic [ADDR_W-1:0] LIM_ALL = ADDR_W'(32'h0010_0000);

    // Select the segment and compute the slot from the address bits.
    always_comb begin
        in_fixed = (addr < LIM_ALL);
        if (addr < LIM_64K) begin
            slot = FIX_IDX_W'(addr[18:16]);
        end else if (addr < LIM_16K) begin
            slot = FIX_IDX_W'(addr[17:14]) + FIX_IDX_W'(8);
        end else begin
            slot = FIX_IDX_W'(addr[17:12]) + FIX_IDX_W'(24);
        end
    end

endmodule

// File: rtl/mtr_range_match.sv
// Compares one variable region against the latched start and inclusive
// end addresses. Page offset bits 11:0 are excluded from the comparison.
module mtr_range_match #(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] base_w,
    input  logic [ADDR_W-1:0] mask_w,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [ADDR_W-1:0] e_addr,
    output logic              active,
    output logic              s_hit,
    output logic              e_hit,
    output logic [7:0]        ty
);

    localparam logic [ADDR_W-1:0] PAGE_KEEP = ~ADDR_W'(12'hFFF);

    logic [ADDR_W-1:0] m_eff;
    logic [ADDR_W-1:0] b_eff;

    // Mask out page offsets, then test both ends of the range.
    always_comb begin
        m_eff  = mask_w & PAGE_KEEP;
        b_eff  = base_w & m_eff;
        active = mask_w[11];
        ty     = base_w[7:0];
        s_hit  = ((s_addr & m_eff) == b_eff);
        e_hit  = ((e_addr & m_eff) == b_eff);
    end

endmodule

// File: rtl/mtr_scan_ctrl.sv
// Sequencer for one lookup: latch the request, take the early exits
// (off, fixed table, variables disabled), scan one region per cycle,
// apply the top-of-memory-2 override, then pulse done. Assumes the
// configuration is stable for the duration of a lookup.
module mtr_scan_ctrl
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 8,
    parameter int VIDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_end,
    input  logic              loaded,
    input  logic [7:0]        def_type,
    input  logic              fix_en,
    input  logic              var_en,
    input  logic              fix_present,
    input  logic [ADDR_W-1:0] tom2,
    input  logic              fix_hit,
    input  logic [7:0]        fix_type,
    input  logic              v_active,
    input  logic              v_s_hit,
    input  logic              v_e_hit,
    input  logic [7:0]        v_ty,
    output logic [ADDR_W-1:0] s_q,
    output logic [ADDR_W-1:0] e_q,
    output logic [VIDX_W-1:0] scan_idx,
    output logic              busy,
    output logic              done,
    output logic [7:0]        result
);

    localparam logic [VIDX_W-1:0] LAST_IDX = VIDX_W'(NUM_VAR - 1);
    localparam logic [ADDR_W-1:0] FOUR_GIB = {{(ADDR_W-33){1'b0}}, 1'b1, 32'h0};

    scan_state_e state;
    logic        have_q;
    logic [7:0]  acc_q;
    logic [7:0]  res_q;
    merge_t      mrg;
    logic        in_tom2;

    // Precedence merge of the current region against the accumulator.
    always_comb begin
        mrg     = merge_types(have_q, acc_q, v_ty);
        in_tom2 = (tom2 != '0) && (s_q >= FOUR_GIB) && (e_q < tom2);
    end

    // Lookup state machine and result accumulation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            s_q      <= '0;
            e_q      <= '0;
            scan_idx <= '0;
            have_q   <= 1'b0;
            acc_q    <= 8'h00;
            res_q    <= 8'h00;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_start) begin
                        s_q   <= req_base;
                        e_q   <= req_end - ADDR_W'(1);
                        state <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    scan_idx <= '0;
                    have_q   <= 1'b0;
                    acc_q    <= 8'h00;
                    if (!loaded || (!fix_en && !var_en)) begin
                        res_q <= MT_OFF;
                        state <= ST_FIN;
                    end else if (fix_present && fix_en && fix_hit) begin
                        res_q <= fix_type;
                        state <= ST_FIN;
                    end else if (!var_en) begin
                        res_q <= def_type;
                        state <= ST_FIN;
                    end else begin
                        state <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (v_active && (v_s_hit != v_e_hit)) begin
                        res_q <= MT_MIXED;
                        state <= ST_FIN;
                    end else if (v_active && v_s_hit && mrg.conflict) begin
                        res_q <= MT_UC;
                        state <= ST_FIN;
                    end else begin
                        if (v_active && v_s_hit) begin
                            acc_q  <= mrg.ty;
                            have_q <= 1'b1;
                        end
                        if (scan_idx == LAST_IDX) begin
                            state <= ST_POST;
                        end else begin
                            scan_idx <= scan_idx + VIDX_W'(1);
                        end
                    end
                end
                ST_POST: begin
                    if (in_tom2) begin
                        res_q <= MT_WB;
                    end else if (have_q) begin
                        res_q <= acc_q;
                    end else begin
                        res_q <= def_type;
                    end
                    state <= ST_FIN;
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Handshake outputs follow the state register directly.
    always_comb begin
        busy   = (state != ST_IDLE);
        done   = (state == ST_FIN);
        result = res_q;
    end

endmodule

// File: rtl/memtype_resolver.sv
// Top of the memory type range resolver: ties configuration storage,
// fixed table indexing, a single shared region comparator and the scan
// sequencer together. Assumes ADDR_W > 32 and configuration writes only
// while idle.
module memtype_resolver
    import mtr_pkg::*;
#(
    parameter  int ADDR_W    = 40,
    parameter  int NUM_VAR   = 8,
    localparam int VIDX_W    = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1,
    localparam int CFG_IDX_W = (FIX_IDX_W > VIDX_W) ? FIX_IDX_W : VIDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_kind,
    input  logic [CFG_IDX_W-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_data,
    input  logic                 req_start,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [ADDR_W-1:0]    req_end,
    output logic                 busy,
    output logic                 done,
    output logic [7:0]           result
);

    logic                           loaded;
    logic [7:0]                     def_type;
    logic                           fix_en;
    logic                           var_en;
    logic                           fix_present;
    logic [ADDR_W-1:0]              tom2;
    logic [FIX_SLOTS-1:0][7:0]      fix_tab;
    logic [NUM_VAR-1:0][ADDR_W-1:0] base_w;
    logic [NUM_VAR-1:0][ADDR_W-1:0] mask_w;

    logic [ADDR_W-1:0]    s_q;
    logic [ADDR_W-1:0]    e_q;
    logic [VIDX_W-1:0]    scan_idx;
    logic                 fix_hit;
    logic [FIX_IDX_W-1:0] fix_slot;
    logic [7:0]           fix_type;
    logic [ADDR_W-1:0]    sel_base;
    logic [ADDR_W-1:0]    sel_mask;
    logic                 v_active;
    logic                 v_s_hit;
    logic                 v_e_hit;
    logic [7:0]           v_ty;

    mtr_cfg_store #(
        .ADDR_W    (ADDR_W),
        .NUM_VAR   (NUM_VAR),
        .CFG_IDX_W (CFG_IDX_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .kind        (cfg_kind),
        .idx         (cfg_idx),
        .data        (cfg_data),
        .loaded      (loaded),
        .def_type    (def_type),
        .fix_en      (fix_en),
        .var_en      (var_en),
        .fix_present (fix_present),
        .tom2        (tom2),
        .fix_tab     (fix_tab),
        .base_w      (base_w),
        .mask_w      (mask_w)
    );

    mtr_fixed_index #(
        .ADDR_W (ADDR_W)
    ) u_fix_idx (
        .addr     (s_q),
        .in_fixed (fix_hit),
        .slot     (fix_slot)
    );

    // Select the fixed byte and the region currently being scanned.
    always_comb begin
        fix_type = fix_tab[fix_slot];
        sel_base = base_w[scan_idx];
        sel_mask = mask_w[scan_idx];
    end

    mtr_range_match #(
        .ADDR_W (ADDR_W)
    ) u_match (
        .base_w (sel_base),
        .mask_w (sel_mask),
        .s_addr (s_q),
        .e_addr (e_q),
        .active (v_active),
        .s_hit  (v_s_hit),
        .e_hit  (v_e_hit),
        .ty     (v_ty)
    );

    mtr_scan_ctrl #(
        .ADDR_W  (ADDR_W),
        .NUM_VAR (NUM_VAR),
        .VIDX_W  (VIDX_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_start   (req_start),
        .req_base    (req_base),
        .req_end     (req_end),
        .loaded      (loaded),
        .def_type    (def_type),
        .fix_en      (fix_en),
        .var_en      (var_en),
        .fix_present (fix_present),
        .tom2        (tom2),
        .fix_hit     (fix_hit),
        .fix_type    (fix_type),
        .v_active    (v_active),
        .v_s_hit     (v_s_hit),
        .v_e_hit     (v_e_hit),
        .v_ty        (v_ty),
        .s_q         (s_q),
        .e_q         (e_q),
        .scan_idx    (scan_idx),
        .busy        (busy),
        .done        (done),
        .result      (result)
    );

endmodule

// File: rtl/memtype_resolver_checker.sv
// Protocol and result properties for memtype_resolver, attached by bind.
// Assumes configuration is not rewritten during a lookup.
module memtype_resolver_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_start,
    input logic       busy,
    input logic       done,
    input logic [7:0] result,
    input logic       cfg_loaded,
    input logic       var_en
);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_start) |=> busy);

    a_r1_unloaded_off: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cfg_loaded) |-> (result == 8'hFF));

    a_r6_mixed_from_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 8'hFE) |-> var_en);

endmodule

bind memtype_resolver memtype_resolver_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .cfg_loaded (loaded),
    .var_en     (var_en)
);

// File: tb/memtype_resolver_test.sv
`timescale 1ns/1ps
module memtype_resolver_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_kind = 3'd0;
    logic [6:0]  cfg_idx = 7'd0;
    logic [39:0] cfg_data = 40'd0;
    logic        req_start = 1'b0;
    logic [39:0] req_base = 40'd0;
    logic [39:0] req_end = 40'd0;
    logic        busy;
    logic        done;
    logic [7:0]  result;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    memtype_resolver uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .cfg_idx   (cfg_idx),
        .cfg_data  (cfg_data),
        .req_start (req_start),
        .req_base  (req_base),
        .req_end   (req_end),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    localparam logic [39:0] CTRL_ALL  = 40'h705;
    localparam logic [39:0] CTRL_NOV  = 40'h505;
    localparam logic [39:0] CTRL_NOF  = 40'h205;
    localparam logic [39:0] CTRL_NONE = 40'h005;

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic cfg(input logic [2:0] k, input int i, input logic [39:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = 7'(i); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic lookup(input logic [39:0] s, input logic [39:0] e,
                          output logic [7:0] r, output int lat);
        @(negedge clk);
        req_start = 1'b1; req_base = s; req_end = e;
        @(posedge clk);
        lat = 0;
        @(negedge clk);
        req_start = 1'b0;
        while (!done && lat < 500) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        r = result;
    endtask

    task automatic expect_type(input string tag, input logic [39:0] s,
                               input logic [39:0] e, input logic [7:0] exp);
        logic [7:0] r;
        int lat;
        lookup(s, e, r, lat);
        check(tag, {56'd0, r}, {56'd0, exp});
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        check("R10 reset busy", {63'd0, busy}, 64'd0);
        check("R10 reset done", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_off();
        expect_type("R1 unloaded", 40'h0, 40'h1000, 8'hFF);
        cfg(3'd0, 0, CTRL_NONE);
        expect_type("R1 enables clear", 40'h30000, 40'h31000, 8'hFF);
    endtask

    task automatic t_load();
        for (int i = 0; i < 88; i++) cfg(3'd1, i, 40'(i + 16));
        cfg(3'd2, 0, 40'h01_0000_0006); cfg(3'd3, 0, 40'hFF_C000_0800);
        cfg(3'd2, 1, 40'h01_0000_0004); cfg(3'd3, 1, 40'hFF_F000_0800);
        cfg(3'd2, 2, 40'h00_2000_0000); cfg(3'd3, 2, 40'hFF_F000_0800);
        cfg(3'd2, 3, 40'h00_3000_0001); cfg(3'd3, 3, 40'hFF_F000_0800);
        cfg(3'd2, 4, 40'h00_3000_0005); cfg(3'd3, 4, 40'hFF_F800_0800);
        cfg(3'd2, 5, 40'h00_4000_0006); cfg(3'd3, 5, 40'hFF_F000_0000);
        cfg(3'd2, 6, 40'h00_5000_0000); cfg(3'd3, 6, 40'hFF_F000_0800);
        cfg(3'd2, 7, 40'h00_6000_0F06); cfg(3'd3, 7, 40'hFF_F000_0FFF);
        cfg(3'd0, 0, CTRL_ALL);
    endtask

    task automatic t_fixed();
        expect_type("R3 64K segment", 40'h30000, 40'h31000, 8'h13);
        expect_type("R3 start only", 40'h30000, 40'h200_0000, 8'h13);
        expect_type("R3 16K segment", 40'h94000, 40'h95000, 8'h1D);
        expect_type("R3 4K segment", 40'hC5000, 40'hC6000, 8'h2D);
        expect_type("R3 last slot", 40'hFF000, 40'h100000, 8'h67);
    endtask

    task automatic t_var();
        logic [7:0] r;
        int lat;
        lookup(40'h01_0000_0000, 40'h01_0000_1000, r, lat);
        check("R7 WB with WT", {56'd0, r}, 64'h4);
        check("R10 full scan latency", 64'(lat), 64'd10);
        expect_type("R7 WC with WP", 40'h3000_0000, 40'h3000_1000, 8'h00);
        expect_type("R7 single UC", 40'h5000_0000, 40'h5000_1000, 8'h00);
        expect_type("R6 straddle", 40'h3000_0000, 40'h3800_1000, 8'hFE);
        expect_type("R2 inclusive end", 40'h3000_0000, 40'h3800_0000, 8'h00);
        expect_type("R5 inactive region", 40'h4000_0000, 40'h4000_1000, 8'h05);
        expect_type("R5 low bits ignored", 40'h6000_0000, 40'h6000_1000, 8'h06);
        expect_type("R9 no match", 40'h8000_0000, 40'h8000_1000, 8'h05);
        expect_type("R5 WB region alone", 40'h01_2000_0000, 40'h01_2000_1000, 8'h06);
    endtask

    task automatic t_busy_ignore();
        int extra = 0;
        @(negedge clk);
        req_start = 1'b1; req_base = 40'h01_0000_0000; req_end = 40'h01_0000_1000;
        @(negedge clk);
        req_start = 1'b0;
        @(negedge clk);
        req_start = 1'b1; req_base = 40'h3000_0000; req_end = 40'h3000_1000;
        @(negedge clk);
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 0; i < 40 && !done; i++) @(negedge clk);
        check("R10 request ignored while busy", {56'd0, result}, 64'h4);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        check("R10 single done pulse", 64'(extra), 64'd0);
        check("R10 idle after", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_modes();
        cfg(3'd0, 0, CTRL_NOV);
        expect_type("R4 variables off", 40'h6000_0000, 40'h6000_1000, 8'h05);
        expect_type("R3 fixed with variables off", 40'h30000, 40'h31000, 8'h13);
        cfg(3'd0, 0, CTRL_NOF);
        expect_type("R3 fixed off uses scan", 40'h30000, 40'h31000, 8'h05);
        cfg(3'd0, 0, CTRL_ALL);
    endtask

    task automatic t_tom2();
        cfg(3'd4, 0, 40'h02_0000_0000);
        expect_type("R8 override to WB", 40'h01_0000_0000, 40'h01_0000_1000, 8'h06);
        expect_type("R8 end beyond limit", 40'h01_FFFF_F000, 40'h02_0000_1000, 8'h05);
        expect_type("R8 start below 4G", 40'h8000_0000, 40'h8000_1000, 8'h05);
        expect_type("R8 UC below 4G kept", 40'h5000_0000, 40'h5000_1000, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_off();
        t_load();
        t_fixed();
        t_var();
        t_busy_ignore();
        t_modes();
        t_tom2();
        summary();
        $finish;
    end

endmodule